// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block buffers 9-bit words between two independent clock domains. A producer writes on its own clock and a consumer reads on another; the two clocks may also be the same net. Depth is a parameter, a power of two from 64 to 8192 words. Write and read pointers are kept in binary inside their own domains and cross to the other domain as Gray codes through two-flop synchronisers. Empty and almost-empty are produced in the read domain, and full and almost-full in the write domain.

The almost-empty and almost-full thresholds are programmable to one word. They are loaded and read back through the ordinary data buses. The second write enable has two roles. When it is high it permits a normal write. When it is low it selects the threshold registers, which are then visited in a fixed rotating order on both the load side and the readback side. The output bus is driven only while the output enable is active.

Top module: `dcfifo`

## Requirements
- R1: Reset is synchronous and active low on both clocks. Afterwards `empty`=1, `almost_empty`=1, `full`=0 and `almost_full`=0. The registered output word is 0, and both thresholds hold 7.
- R2: A rising `wclk` edge stores `din` into the buffer when `wen1_n`=0, `wen2_ld`=1 and the buffer is not full. With `wen1_n`=1 nothing is stored.
- R3: A write attempt while `full`=1 is dropped and never appears at the read side.
- R4: A rising `rclk` edge moves the oldest word to `dout` when `ren1_n`=0, `ren2_n`=0, `wen2_ld`=1 and the buffer is not empty. Words leave in write order. A read attempt while `empty`=1 leaves `dout` unchanged.
- R5: A read needs both read enables low. With only one of them low, nothing is removed.
- R6: With `wen1_n`=0 and `wen2_ld`=0, a `wclk` edge loads `din` into a threshold register instead of the buffer. The slot cycles almost-empty, then almost-full, then back again. When the threshold is wider than 9 bits (depth above 512), the cycle has four steps: almost-empty bits [8:0], almost-empty upper bits, almost-full bits [8:0], almost-full upper bits. Upper bits are taken from the low end of `din`.
- R7: With `ren1_n`=0, `ren2_n`=0 and `wen2_ld`=0, an `rclk` edge places the current readback slot on `dout`, zero-extended. Readback follows the same slot order as R6, with its own rotating pointer, which is reset by R1.
- R8: `almost_empty` is 1 exactly when the stored word count is at or below the almost-empty threshold. `empty` is 1 exactly when the count is 0.
- R9: `almost_full` is 1 exactly when the free location count is at or below the almost-full threshold. `full` is 1 exactly when no location is free.
- R10: `dout` is high impedance while `oe_n`=1 and shows the registered output word while `oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | High: second write enable; low: threshold register access |
| din | input | 9 | Write data or threshold value |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data or threshold readback, high impedance when disabled |
| empty | output | 1 | No word stored (read domain) |
| full | output | 1 | No location free (write domain) |
| almost_empty | output | 1 | Stored count at or below threshold (read domain) |
| almost_full | output | 1 | Free count at or below threshold (write domain) |

## Verification
The assertions assume that `rst_n` stays low for at least two edges of each clock. They also assume that `wen2_ld` does not change while a read-side access is being made. The threshold values are read directly by the read domain, so they are treated as quasi-static and are only reprogrammed while the buffer is idle. The stimulus keeps to these assumptions: it moves `wen2_ld` only while both read enables are high, and it loads thresholds before any data traffic. Every flag is then sampled after enough edges of both clocks for the pointers to cross.

// File: rtl/dcfifo_pkg.sv
// Shared helpers for the dual-clock FIFO.
// Assumes threshold width never exceeds twice the data width.
package dcfifo_pkg;

    typedef enum logic {OFS_EMPTY = 1'b0, OFS_FULL = 1'b1} ofs_sel_e;

    // Number of slots in the threshold access rotation.
    function automatic int slot_steps(input int ow, input int dw);
        return (ow > dw) ? 4 : 2;
    endfunction

    // Which threshold register a rotation slot addresses.
    function automatic ofs_sel_e slot_reg(input logic [1:0] slot, input bit four);
        if (four)
            return slot[1] ? OFS_FULL : OFS_EMPTY;
        return slot[0] ? OFS_FULL : OFS_EMPTY;
    endfunction

endpackage

// File: rtl/dcfifo_ptr_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, followed by Gray-to-binary.
// Assumes gray_in changes by at most one bit per source clock edge.
module dcfifo_ptr_sync #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above it.
    always_comb begin
        for (int i = 0; i < PW; i++)
            bin_out[i] = ^(sync_q >> i);
    end

endmodule

// File: rtl/dcfifo_mem.sv
// Storage array: synchronous write on wclk, combinational read address path.
// Assumes the read controller registers the word it takes.
module dcfifo_mem #(
    parameter int DW    = 9,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dcfifo_ofs_regs.sv
// Threshold registers and their load-slot rotation, in the write domain.
// Assumes OW <= 2*DW; values are quasi-static for the read domain.
module dcfifo_ofs_regs #(
    parameter int DW = 9,
    parameter int OW = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [DW-1:0] din,
    output logic [OW-1:0] ae_ofs,
    output logic [OW-1:0] af_ofs
);
    localparam int          STEPS = dcfifo_pkg::slot_steps(OW, DW);
    localparam bit          FOUR  = (STEPS == 4);
    localparam logic [OW-1:0] DEF = OW'(7);
    localparam logic [1:0]  LAST  = 2'(STEPS - 1);

    logic [1:0] slot;

    // Advance the load slot on each threshold write, wrapping after the last.
    always_ff @(posedge wclk) begin
        if (!rst_n)
            slot <= 2'd0;
        else if (ld_we)
            slot <= (slot == LAST) ? 2'd0 : slot + 2'd1;
    end

    generate
        if (OW <= DW) begin : g_narrow
            // Whole threshold loaded in one step.
            always_ff @(posedge wclk) begin
                if (!rst_n) begin
                    ae_ofs <= DEF;
                    af_ofs <= DEF;
                end else if (ld_we) begin
                    if (dcfifo_pkg::slot_reg(slot, FOUR) == dcfifo_pkg::OFS_EMPTY)
                        ae_ofs <= din[OW-1:0];
                    else
                        af_ofs <= din[OW-1:0];
                end
            end
        end else begin : g_wide
            localparam int HW = OW - DW;
            // Low part then high part of each threshold.
            always_ff @(posedge wclk) begin
                if (!rst_n) begin
                    ae_ofs <= DEF;
                    af_ofs <= DEF;
                end else if (ld_we) begin
                    case (slot)
                        2'd0:    ae_ofs[DW-1:0]  <= din;
                        2'd1:    ae_ofs[OW-1:DW] <= din[HW-1:0];
                        2'd2:    af_ofs[DW-1:0]  <= din;
                        default: af_ofs[OW-1:DW] <= din[HW-1:0];
                    endcase
                end
            end
        end
    endgenerate

    a_r6_slot_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        !ld_we |=> $stable(slot));
    a_r6_slot_range: assert property (@(posedge wclk) disable iff (!rst_n)
        slot <= LAST);

endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-domain pointer and full/almost-full flags.
// Assumes rbin_sync is the read pointer already brought into wclk.
module dcfifo_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int OW    = 6
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic [AW:0] rbin_sync,
    input  logic [OW-1:0] af_ofs,
    output logic        we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray,
    output logic        full,
    output logic        almost_full
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] used_nx;
    logic [PW-1:0] free_nx;

    assign we      = wr_req & ~full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + PW'(we);
    assign used_nx = wbin_nx - rbin_sync;
    assign free_nx = CAP - used_nx;

    // Pointer update and registered write-side flags.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            full        <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wbin_nx ^ (wbin_nx >> 1);
            full        <= (used_nx == CAP);
            almost_full <= (free_nx <= PW'(af_ofs));
        end
    end

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && full) |=> $stable(wbin));
    a_r9_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> almost_full);
    a_r2_gray_one_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-domain pointer, empty/almost-empty flags, output register and
// threshold readback rotation.
// Assumes wbin_sync is the write pointer already in rclk, and that the
// thresholds do not change while data is moving.
module dcfifo_rd_ctl #(
    parameter int DW = 9,
    parameter int AW = 6,
    parameter int OW = 6
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rb_req,
    input  logic [AW:0]   wbin_sync,
    input  logic [OW-1:0] ae_ofs,
    input  logic [OW-1:0] af_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          almost_empty,
    output logic [DW-1:0] dout_q
);
    localparam int         PW    = AW + 1;
    localparam int         STEPS = dcfifo_pkg::slot_steps(OW, DW);
    localparam logic [1:0] LAST  = 2'(STEPS - 1);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] cnt_nx;
    logic          re;
    logic [1:0]    rb_slot;
    logic [DW-1:0] rb_word;

    assign re      = rd_req & ~empty;
    assign raddr   = rbin[AW-1:0];
    assign rbin_nx = rbin + PW'(re);
    assign cnt_nx  = wbin_sync - rbin_nx;

    // Pointer update and registered read-side flags.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin         <= '0;
            rgray        <= '0;
            empty        <= 1'b1;
            almost_empty <= 1'b1;
        end else begin
            rbin         <= rbin_nx;
            rgray        <= rbin_nx ^ (rbin_nx >> 1);
            empty        <= (cnt_nx == '0);
            almost_empty <= (cnt_nx <= PW'(ae_ofs));
        end
    end

    // Readback slot rotation, independent of the load-side slot.
    always_ff @(posedge rclk) begin
        if (!rst_n)
            rb_slot <= 2'd0;
        else if (rb_req)
            rb_slot <= (rb_slot == LAST) ? 2'd0 : rb_slot + 2'd1;
    end

    generate
        if (OW <= DW) begin : g_rb_narrow
            // One slot per threshold.
            always_comb begin
                if (dcfifo_pkg::slot_reg(rb_slot, 1'b0) == dcfifo_pkg::OFS_EMPTY)
                    rb_word = DW'(ae_ofs);
                else
                    rb_word = DW'(af_ofs);
            end
        end else begin : g_rb_wide
            // Low and high part of each threshold.
            always_comb begin
                case (rb_slot)
                    2'd0:    rb_word = ae_ofs[DW-1:0];
                    2'd1:    rb_word = DW'(ae_ofs[OW-1:DW]);
                    2'd2:    rb_word = af_ofs[DW-1:0];
                    default: rb_word = DW'(af_ofs[OW-1:DW]);
                endcase
            end
        end
    endgenerate

    // Output register: data word on a read, threshold on a readback.
    always_ff @(posedge rclk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (re)
            dout_q <= mem_rdata;
        else if (rb_req)
            dout_q <= rb_word;
    end

    a_r4_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_req && empty) |=> ($stable(rbin) && $stable(dout_q)));
    a_r8_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> almost_empty);
    a_r7_rb_slot_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        !rb_req |=> $stable(rb_slot));
    a_r4_gray_one_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/dcfifo.sv
// Top level: decodes the enable pins and ties together the storage array,
// the two domain controllers, the pointer synchronisers and the thresholds.
// Assumes rst_n is held low across at least two edges of each clock.
module dcfifo #(
    parameter int DW    = 9,
    parameter int DEPTH = 64
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [DW-1:0] din,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW;
    localparam int PW = AW + 1;

    logic          wr_req, ld_we, rd_both, rd_req, rb_req;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wbin_sync, rbin_sync;
    logic [OW-1:0] ae_ofs, af_ofs;
    logic [DW-1:0] mem_rdata, dout_q;

    assign wr_req  = ~wen1_n & wen2_ld;
    assign ld_we   = ~wen1_n & ~wen2_ld;
    assign rd_both = ~ren1_n & ~ren2_n;
    assign rd_req  = rd_both & wen2_ld;
    assign rb_req  = rd_both & ~wen2_ld;

    dcfifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcfifo_ofs_regs #(.DW(DW), .OW(OW)) u_ofs (
        .wclk(wclk), .rst_n(rst_n), .ld_we(ld_we), .din(din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rbin_sync(rbin_sync),
        .af_ofs(af_ofs), .we(we), .waddr(waddr), .wgray(wgray),
        .full(full), .almost_full(almost_full)
    );

    dcfifo_rd_ctl #(.DW(DW), .AW(AW), .OW(OW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .rb_req(rb_req),
        .wbin_sync(wbin_sync), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
        .empty(empty), .almost_empty(almost_empty), .dout_q(dout_q)
    );

    dcfifo_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_sync)
    );

    dcfifo_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_sync)
    );

    // Drive the bus only while the output is enabled (R10).
    assign dout = oe_n ? 'z : dout_q;

endmodule

// File: tb/tb_dcfifo.sv
module tb_dcfifo;
    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic rst_n = 1'b0;

    logic       wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       empty, full, almost_empty, almost_full;

    logic       w_wen1_n = 1'b1, w_wen2_ld = 1'b1, w_ren1_n = 1'b1, w_ren2_n = 1'b1;
    logic [8:0] w_din = '0;
    logic [8:0] w_dout;
    logic       w_empty, w_full, w_ae, w_af;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5ns wclk = ~wclk;
    always #7ns rclk = ~rclk;

    dcfifo #(.DW(9), .DEPTH(64)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
        .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    dcfifo #(.DW(9), .DEPTH(1024)) dut_wide (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(w_wen1_n), .wen2_ld(w_wen2_ld),
        .din(w_din), .ren1_n(w_ren1_n), .ren2_n(w_ren2_n), .oe_n(1'b0), .dout(w_dout),
        .empty(w_empty), .full(w_full), .almost_empty(w_ae), .almost_full(w_af)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) & 511);
    endfunction

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
    endtask

    task automatic wr_word(input logic [8:0] d);
        @(negedge wclk);
        wen1_n = 1'b0; wen2_ld = 1'b1; din = d;
        @(negedge wclk);
        wen1_n = 1'b1;
    endtask

    task automatic ld_word(input bit wide, input logic [8:0] d);
        @(negedge wclk);
        if (wide) begin w_wen1_n = 1'b0; w_wen2_ld = 1'b0; w_din = d; end
        else      begin wen1_n = 1'b0;   wen2_ld = 1'b0;   din = d;   end
        @(negedge wclk);
        if (wide) begin w_wen1_n = 1'b1; w_wen2_ld = 1'b1; end
        else      begin wen1_n = 1'b1;   wen2_ld = 1'b1;   end
    endtask

    task automatic rd_word(output logic [8:0] got);
        @(negedge rclk);
        ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b1;
        got = dout;
    endtask

    task automatic rb_word(input bit wide, output logic [8:0] got);
        @(negedge rclk);
        if (wide) begin w_wen2_ld = 1'b0; @(negedge rclk); w_ren1_n = 1'b0; w_ren2_n = 1'b0; end
        else      begin wen2_ld = 1'b0;   @(negedge rclk); ren1_n = 1'b0;   ren2_n = 1'b0;   end
        @(negedge rclk);
        if (wide) begin w_ren1_n = 1'b1; w_ren2_n = 1'b1; got = w_dout; end
        else      begin ren1_n = 1'b1;   ren2_n = 1'b1;   got = dout;   end
        @(negedge rclk);
        if (wide) w_wen2_ld = 1'b1;
        else      wen2_ld = 1'b1;
    endtask

    task automatic t_reset();
        check("R10 disabled bus", dout, 9'bz);
        check("R1 empty", 9'(empty), 9'd1);
        check("R1 almost_empty", 9'(almost_empty), 9'd1);
        check("R1 full", 9'(full), 9'd0);
        check("R1 almost_full", 9'(almost_full), 9'd0);
        oe_n = 1'b0;
        #1ns;
        check("R10 R1 enabled bus reset word", dout, 9'd0);
    endtask

    task automatic t_default_offsets();
        logic [8:0] got;
        for (int i = 0; i < 4; i++) begin
            rb_word(1'b0, got);
            check("R1 R7 default threshold readback", got, 9'd7);
        end
    endtask

    task automatic t_program();
        logic [8:0] got;
        ld_word(1'b0, 9'd3);
        ld_word(1'b0, 9'd5);
        for (int i = 0; i < 4; i++) begin
            rb_word(1'b0, got);
            check("R6 R7 programmed readback order", got, (i % 2 == 0) ? 9'd3 : 9'd5);
        end
        settle();
        check("R7 readback leaves buffer empty", 9'(empty), 9'd1);
    endtask

    task automatic t_write_gate();
        @(negedge wclk);
        wen1_n = 1'b1; wen2_ld = 1'b1; din = 9'h155;
        repeat (3) @(negedge wclk);
        settle();
        check("R2 no write with wen1_n high", 9'(empty), 9'd1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 3; i++) wr_word(pat(i));
        settle();
        check("R8 count 3 not empty", 9'(empty), 9'd0);
        check("R8 count 3 at threshold 3", 9'(almost_empty), 9'd1);
        wr_word(pat(3));
        settle();
        check("R8 count 4 above threshold", 9'(almost_empty), 9'd0);
        for (int i = 4; i < 58; i++) wr_word(pat(i));
        settle();
        check("R9 free 6 above threshold 5", 9'(almost_full), 9'd0);
        wr_word(pat(58));
        settle();
        check("R9 free 5 at threshold", 9'(almost_full), 9'd1);
        check("R9 not yet full", 9'(full), 9'd0);
        for (int i = 59; i < 64; i++) wr_word(pat(i));
        settle();
        check("R9 full at depth", 9'(full), 9'd1);
        wr_word(9'h1FF);
        settle();
        check("R3 still full after dropped write", 9'(full), 9'd1);
    endtask

    task automatic t_single_enable();
        @(negedge rclk);
        ren1_n = 1'b0; ren2_n = 1'b1;
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b0;
        @(negedge rclk);
        ren2_n = 1'b1;
        settle();
        check("R5 single enable removes nothing", 9'(full), 9'd1);
    endtask

    task automatic t_drain();
        logic [8:0] got;
        for (int i = 0; i < 64; i++) begin
            rd_word(got);
            if (i == 0 || i == 31 || i == 63)
                check("R4 R2 data order", got, pat(i));
            else if (got !== pat(i))
                check("R4 data order", got, pat(i));
        end
        settle();
        check("R8 empty after drain", 9'(empty), 9'd1);
        check("R8 almost_empty after drain", 9'(almost_empty), 9'd1);
        check("R9 not full after drain", 9'(full), 9'd0);
        check("R9 not almost_full after drain", 9'(almost_full), 9'd0);
        rd_word(got);
        check("R4 R3 read when empty holds output", got, pat(63));
    endtask

    task automatic t_wide();
        logic [8:0] got;
        logic [8:0] exp_def [4] = '{9'd7, 9'd0, 9'd7, 9'd0};
        logic [8:0] exp_new [4] = '{9'h0AB, 9'h001, 9'h1C4, 9'h000};
        for (int i = 0; i < 4; i++) begin
            rb_word(1'b1, got);
            check("R6 R7 four-step default readback", got, exp_def[i]);
        end
        ld_word(1'b1, 9'h0AB);
        ld_word(1'b1, 9'h003);
        ld_word(1'b1, 9'h1C4);
        ld_word(1'b1, 9'h002);
        for (int i = 0; i < 4; i++) begin
            rb_word(1'b1, got);
            check("R6 R7 four-step programmed readback", got, exp_new[i]);
        end
    endtask

    task automatic t_disable();
        oe_n = 1'b1;
        #1ns;
        check("R10 bus released", dout, 9'bz);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_500_000ns;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (6) @(negedge rclk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_default_offsets();
        t_program();
        t_write_gate();
        t_fill();
        t_single_enable();
        t_drain();
        t_wide();
        t_disable();
        finish_run();
    end

endmodule